// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power control register of a small 8-bit microcontroller core and sequences the core between its running state and three low-power modes: a light halt (Idle), a deep halt (Stop) and a full power-off (Shutdown). Software writes mode bits into the register. The controller enters the selected mode only when the CPU reports, through a retire strobe, that an instruction has completed. While a mode is active, the controller drives registered gates to the CPU, to the peripherals and timers, to the interrupt unit and to the clock, and it raises a shutdown request.

Each mode has its own exit rule. Idle ends on any interrupt whose enable line is high, and the Idle bit then clears itself. Stop ignores every interrupt and ends only on the synchronous reset. The clock keeps running in Stop. Shutdown stops the clock and ends only when an active-low wake pin is held low. That pin first passes through a flop synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode register holds three bits: bit 0 selects Idle, bit 1 selects Stop and bit 2 selects Shutdown. A write strobe in the running state replaces all three bits with the write data. The register contents appear on the readback port one clock after the write.
- R2: A mode takes effect at the first clock edge on which the retire strobe is high and the register already holds a set mode bit. A retire strobe in the same cycle as the write that sets a bit does not enter the mode.
- R3: When several mode bits are set, Shutdown takes priority over Stop, and Stop takes priority over Idle.
- R4: In Idle, the CPU halt is high, while the peripheral gate, the interrupt gate and the clock enable stay high and the shutdown request is low.
- R5: In Idle, an interrupt that has its enable line high returns the controller to running at the next edge and clears bit 0 at that same edge. A request whose enable line is low has no effect.
- R6: In Stop, the CPU halt is high, the peripheral gate and the interrupt gate are low, the clock enable stays high and the shutdown request is low.
- R7: Stop is left only by reset. Enabled interrupts and the wake pin have no effect on it.
- R8: In Shutdown, the CPU halt and the shutdown request are high, and the peripheral gate, the interrupt gate and the clock enable are low.
- R9: The wake pin passes through a two-flop synchronizer. If the pin is sampled low at two consecutive edges k and k+1, the controller leaves Shutdown at edge k+3 and clears bit 2 there. A low level seen at a single edge does not wake it.
- R10: A reset sampled high at an edge clears all mode bits and sets every output to its running value (halt low, peripheral, interrupt and clock gates high, shutdown request low) at that edge.
- R11: While any mode is active, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| pcon_wr | input | 1 | Write strobe for the mode register |
| pcon_wdata | input | 3 | Write data: {shutdown, stop, idle} |
| insn_retire | input | 1 | High for one cycle when an instruction completes |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enable lines |
| gpio_wake_n | input | 1 | Asynchronous active-low wake pin |
| pcon_q | output | 3 | Mode register readback |
| cpu_halt | output | 1 | Halts the CPU |
| periph_en | output | 1 | Enables peripherals and timers |
| irq_gate | output | 1 | Enables the interrupt unit |
| clk_en | output | 1 | System clock enable |
| shutdown_req | output | 1 | Device power-off request |

## Verification
The bench uses the default parameters: eight interrupt lines, two synchronizer stages and a wake filter of two low samples. With these values, the cycle on which Shutdown ends can be counted exactly, so both the wake after a two-cycle low and the absence of a wake after a one-cycle pulse can be checked. Eight lines also let one request be masked while the others stay enabled, which shows that only enabled requests end Idle. Mode entry is checked at the retire strobe after a write and on the retire that shares a cycle with the write.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_BITS = 3;
  localparam int BIT_IDLE  = 0;
  localparam int BIT_STOP  = 1;
  localparam int BIT_SHDN  = 2;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_IDLE   = 2'd1,
    PM_STOP   = 2'd2,
    PM_SHDN   = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic halt;
    logic periph;
    logic irq;
    logic shdn;
    logic clk;
  } pm_gates_t;

  // Shutdown wins over Stop, Stop wins over Idle.
  function automatic pm_state_e pick_mode(input logic [MODE_BITS-1:0] req);
    if (req[BIT_SHDN])      return PM_SHDN;
    else if (req[BIT_STOP]) return PM_STOP;
    else if (req[BIT_IDLE]) return PM_IDLE;
    else                    return PM_ACTIVE;
  endfunction

  function automatic pm_gates_t gates_for(input pm_state_e st);
    pm_gates_t g;
    unique case (st)
      PM_IDLE: g = '{halt: 1'b1, periph: 1'b1, irq: 1'b1, shdn: 1'b0, clk: 1'b1};
      PM_STOP: g = '{halt: 1'b1, periph: 1'b0, irq: 1'b0, shdn: 1'b0, clk: 1'b1};
      PM_SHDN: g = '{halt: 1'b1, periph: 1'b0, irq: 1'b0, shdn: 1'b1, clk: 1'b0};
      default: g = '{halt: 1'b0, periph: 1'b1, irq: 1'b1, shdn: 1'b0, clk: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pmc_wake_det.sv
module pmc_wake_det #(
  parameter int LOW_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  output logic wake
);
  localparam int CW = $clog2(LOW_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOW_CYCLES - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || sync_n)        low_cnt <= '0;
    else if (low_cnt < LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign wake = !sync_n && (low_cnt >= LIMIT);

  // R9: a wake needs the pin low for the full filter window.
  p_wake_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    (wake && LOW_CYCLES > 1) |-> $past(!sync_n));
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [MODE_BITS-1:0] wdata,
  input  logic                 running,
  input  logic                 clr_idle,
  input  logic                 clr_shdn,
  output logic [MODE_BITS-1:0] mode_q
);
  logic [MODE_BITS-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    clr_vec[BIT_IDLE] = clr_idle;
    clr_vec[BIT_SHDN] = clr_shdn;
  end

  genvar b;
  generate
    for (b = 0; b < MODE_BITS; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                mode_q[b] <= 1'b0;
        else if (clr_vec[b])    mode_q[b] <= 1'b0;
        else if (wr && running) mode_q[b] <= wdata[b];
      end
    end
  endgenerate

  // R10: reset clears every mode bit.
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (mode_q == '0));

  // R11: writes while halted leave the register untouched.
  p_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (!running && !clr_idle && !clr_shdn) |=> $stable(mode_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 retire,
  input  logic [MODE_BITS-1:0] mode_q,
  input  logic                 irq_hit,
  input  logic                 wake,
  output pm_state_e            state,
  output logic                 clr_idle,
  output logic                 clr_shdn,
  output pm_gates_t            gates
);
  pm_state_e nxt;

  always_comb begin
    nxt      = state;
    clr_idle = 1'b0;
    clr_shdn = 1'b0;
    unique case (state)
      PM_ACTIVE: if (retire) nxt = pick_mode(mode_q);
      PM_IDLE: if (irq_hit) begin
        nxt      = PM_ACTIVE;
        clr_idle = 1'b1;
      end
      PM_STOP: nxt = PM_STOP;
      PM_SHDN: if (wake) begin
        nxt      = PM_ACTIVE;
        clr_shdn = 1'b1;
      end
      default: nxt = PM_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PM_ACTIVE;
      gates <= gates_for(PM_ACTIVE);
    end else begin
      state <= nxt;
      gates <= gates_for(nxt);
    end
  end

  // R2: the running state is left only on a retire strobe.
  p_entry_on_retire_r2: assert property (@(posedge clk) disable iff (rst)
    (state == PM_ACTIVE && !retire) |=> (state == PM_ACTIVE));

  // R3: Stop beats Idle when both bits are set.
  p_stop_over_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PM_ACTIVE && retire && mode_q[BIT_STOP] && !mode_q[BIT_SHDN])
      |=> (state == PM_STOP));

  // R5: an enabled interrupt ends Idle at the next edge.
  p_idle_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE && irq_hit) |=> (state == PM_ACTIVE && !mode_q[BIT_IDLE]));

  // R7: only reset leaves Stop.
  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (state == PM_STOP) |=> (state == PM_STOP));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ         = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int WAKE_LOW_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pcon_wr,
  input  logic [MODE_BITS-1:0] pcon_wdata,
  input  logic                 insn_retire,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic [NUM_IRQ-1:0]   irq_en,
  input  logic                 gpio_wake_n,
  output logic [MODE_BITS-1:0] pcon_q,
  output logic                 cpu_halt,
  output logic                 periph_en,
  output logic                 irq_gate,
  output logic                 clk_en,
  output logic                 shutdown_req
);
  logic      wake_sync_n;
  logic      wake;
  logic      irq_hit;
  logic      clr_idle;
  logic      clr_shdn;
  pm_state_e state;
  pm_gates_t gates;

  assign irq_hit = |(irq_req & irq_en);

  pmc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .din (gpio_wake_n), .dout (wake_sync_n)
  );

  pmc_wake_det #(.LOW_CYCLES(WAKE_LOW_CYCLES)) u_wake (
    .clk (clk), .rst (rst), .sync_n (wake_sync_n), .wake (wake)
  );

  pmc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (pcon_wr),
    .wdata    (pcon_wdata),
    .running  (state == PM_ACTIVE),
    .clr_idle (clr_idle),
    .clr_shdn (clr_shdn),
    .mode_q   (pcon_q)
  );

  pmc_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .retire   (insn_retire),
    .mode_q   (pcon_q),
    .irq_hit  (irq_hit),
    .wake     (wake),
    .state    (state),
    .clr_idle (clr_idle),
    .clr_shdn (clr_shdn),
    .gates    (gates)
  );

  assign cpu_halt     = gates.halt;
  assign periph_en    = gates.periph;
  assign irq_gate     = gates.irq;
  assign clk_en       = gates.clk;
  assign shutdown_req = gates.shdn;

  // R8: in Shutdown the clock is gated and everything else is off.
  p_shdn_gates_r8: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> (cpu_halt && !clk_en && !periph_en && !irq_gate));

  // R6: the clock keeps running whenever no shutdown is requested.
  p_clk_runs_r6: assert property (@(posedge clk) disable iff (rst)
    !shutdown_req |-> clk_en);
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int NIRQ = 8;
  localparam int NVEC = 9;

  logic            clk = 1'b0;
  logic            rst;
  logic            pcon_wr;
  logic [2:0]      pcon_wdata;
  logic            insn_retire;
  logic [NIRQ-1:0] irq_req;
  logic [NIRQ-1:0] irq_en;
  logic            gpio_wake_n;
  logic [2:0]      pcon_q;
  logic            cpu_halt, periph_en, irq_gate, clk_en, shutdown_req;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NIRQ), .SYNC_STAGES(2), .WAKE_LOW_CYCLES(2)) u_pwr_mode_ctrl (
    .clk (clk), .rst (rst), .pcon_wr (pcon_wr), .pcon_wdata (pcon_wdata),
    .insn_retire (insn_retire), .irq_req (irq_req), .irq_en (irq_en),
    .gpio_wake_n (gpio_wake_n), .pcon_q (pcon_q), .cpu_halt (cpu_halt),
    .periph_en (periph_en), .irq_gate (irq_gate), .clk_en (clk_en),
    .shutdown_req (shutdown_req)
  );

  // Expected word: {halt, periph, irq, shdn, clk, pcon[2:0]}
  localparam logic [7:0] E_ACT  = 8'b01101_000;
  localparam logic [7:0] E_IDLE = 8'b11101_000;
  localparam logic [7:0] E_STOP = 8'b10001_000;
  localparam logic [7:0] E_SHDN = 8'b10010_000;

  // Stimulus {wr, wdata[2:0], retire, irq} then expected word.
  localparam logic [13:0] VEC [NVEC] = '{
    {6'b0_000_0_0, 8'b01101_000},  // R10 running after reset
    {6'b1_001_0_0, 8'b01101_001},  // R1 write idle bit
    {6'b0_000_1_0, 8'b11101_001},  // R2 R4 enter idle on retire
    {6'b0_000_0_0, 8'b11101_001},  // R4 idle holds
    {6'b0_000_0_1, 8'b01101_000},  // R5 enabled irq wakes, bit clears
    {6'b1_011_1_0, 8'b01101_011},  // R2 retire with the write: no entry
    {6'b0_000_1_0, 8'b10001_011},  // R3 R6 stop wins over idle
    {6'b0_000_0_1, 8'b10001_011},  // R7 irq ignored in stop
    {6'b1_001_1_0, 8'b10001_011}   // R11 write ignored in stop
  };

  function automatic logic [7:0] obs();
    return {cpu_halt, periph_en, irq_gate, shutdown_req, clk_en, pcon_q};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pcon_wr = 1'b0; pcon_wdata = 3'b000; insn_retire = 1'b0; irq_req = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle_inputs(); tick(); rst = 1'b0;
  endtask

  task automatic enter(input logic [2:0] bits);
    pcon_wr = 1'b1; pcon_wdata = bits; tick();
    idle_inputs(); insn_retire = 1'b1; tick();
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    irq_en = '1; gpio_wake_n = 1'b1; idle_inputs();
    #1;
    do_reset();
    check("R10", obs(), E_ACT);

    for (int i = 0; i < NVEC; i++) begin
      {pcon_wr, pcon_wdata, insn_retire} = VEC[i][13:9];
      irq_req = VEC[i][8] ? 8'h01 : 8'h00;
      tick();
      check($sformatf("vec%0d", i), obs(), VEC[i][7:0]);
    end
    idle_inputs();

    // R7: wake pin has no effect on stop
    gpio_wake_n = 1'b0;
    repeat (5) tick();
    check("R7", obs(), E_STOP | 8'b011);
    gpio_wake_n = 1'b1;

    // R10: reset leaves stop in one clock
    do_reset();
    check("R10", obs(), E_ACT);

    // R5: masked request does not end idle
    enter(3'b001);
    irq_en = 8'hFE; irq_req = 8'h01; tick();
    check("R5", obs(), E_IDLE | 8'b001);
    irq_req = 8'h80; tick();
    check("R5", obs(), E_ACT);
    irq_en = '1; idle_inputs();

    // R3 R8: shutdown wins over all
    enter(3'b111);
    check("R8", obs(), E_SHDN | 8'b111);
    do_reset();

    enter(3'b100);
    check("R8", obs(), E_SHDN | 8'b100);

    // R9: single-edge low pulse must not wake
    gpio_wake_n = 1'b0; tick(); gpio_wake_n = 1'b1;
    repeat (5) tick();
    check("R9", obs(), E_SHDN | 8'b100);

    // R9: low at edges k and k+1, exit at k+3
    gpio_wake_n = 1'b0; tick();      // edge k
    tick();                          // edge k+1
    gpio_wake_n = 1'b1; tick();      // edge k+2
    check("R9", obs(), E_SHDN | 8'b100);
    tick();                          // edge k+3
    check("R9", obs(), E_ACT);

    // R11 R1: writes work again once running
    pcon_wr = 1'b1; pcon_wdata = 3'b010; tick(); idle_inputs();
    check("R1", obs(), E_ACT | 8'b010);

    // R10: reset from idle
    pcon_wr = 1'b1; pcon_wdata = 3'b001; tick();
    idle_inputs(); insn_retire = 1'b1; tick(); idle_inputs();
    check("R4", obs(), E_IDLE | 8'b001);
    do_reset();
    check("R10", obs(), E_ACT);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule